// File: doc/BRIEF.md
# Replayable Byte-Plus-Tag Queue

This block is a single-clock first-in/first-out buffer for 9-bit words. The ninth bit lets a parity or control tag travel with each byte. Storage is a power-of-two ring, 512 words by default, addressed by internal write and read pointers, so callers never supply addresses. Words enter on a valid/ready stream port. `in_ready` is the inverse of the full condition, and a word is taken on any clock edge where `in_valid` and `in_ready` are both high. Back-pressure is therefore plain: while the buffer is full, `in_ready` is low and the producer must hold its word.

The consumer pulls words with a read strobe. When the strobe is accepted, the word appears on `out_data` one cycle later, marked by a single-cycle `out_valid` pulse. A strobe issued while the buffer is empty is dropped, and no pulse follows.

Three active-low status pins are provided: empty, full and "more than half". A low pulse on the rewind input moves only the read pointer back to the first location. Everything written since reset can then be read out again, and all three flags follow the new pointer distance.

Top module: `retx_fifo`

## Requirements
- R1: Words are 9 bits wide. All 9 bits, including bit 8, come out unchanged and in the order they were accepted.
- R2: While `rst_n` is low, and on the first cycle after it rises, the status pins read as follows: `empty_n`=0, `full_n`=1, `half_n`=1, `in_ready`=1 and `out_valid`=0.
- R3: A word is taken only when `in_valid` is high and the buffer is not full. While the buffer is full, `in_ready` is 0 and offered words leave the stored contents unchanged.
- R4: A read strobe is taken only when the buffer is not empty. While the buffer is empty, a strobe produces no `out_valid` pulse and does not move the read position.
- R5: With no reads after reset, `full_n` goes to 0 after exactly DEPTH accepted words and not before. `empty_n` is 0 exactly when the occupancy is zero.
- R6: `half_n` is 0 exactly when the occupancy exceeds DEPTH/2. It falls after the accepted write that takes the occupancy past DEPTH/2. It rises after the read that brings the occupancy back to DEPTH/2.
- R7: When a write and a read are both accepted in the same cycle, the occupancy and all flags stay unchanged.
- R8: An accepted strobe gives a one-cycle `out_valid` pulse together with the word on the next cycle. A word written into an empty buffer can be read with a strobe issued on the cycle after it is accepted.
- R9: A rewind (`rt_n`=0) sets the read position to the first location and leaves the write position alone. The occupancy becomes the write position, which is the number of words written since reset modulo DEPTH, or DEPTH when the buffer is full at write position zero. The flags follow that value on the next cycle.
- R10: A rewind is honoured only when `in_valid` and `out_req` are both low. Otherwise it is ignored and that cycle's strobes behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Buffer can take a word (not full) |
| in_data | input | WIDTH | Word to store |
| out_req | input | 1 | Read strobe |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a read word |
| out_data | output | WIDTH | Read word |
| rt_n | input | 1 | Active-low rewind of the read pointer |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer is full |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |

## Verification
A write and a read can land on the same edge, and so can a rewind request and a strobe. The first case is provoked by driving `in_valid` and `out_req` together at several occupancies. The bench then expects the flags to stay put, the oldest word to come out, and the new word to appear later in order. The second case is provoked by pulling `rt_n` low while a strobe is active. The bench expects the read to continue from the current position, with the rewind leaving no trace in the data that follows.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } fifo_flags_t;

  localparam fifo_flags_t FLAGS_AT_RESET = '{empty: 1'b1, full: 1'b0, half: 1'b0};
endpackage

// File: rtl/retx_fifo_ptrs.sv
module retx_fifo_ptrs #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          rt_take,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] next_count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] rewind_cnt;

  always_comb begin
    if (count == FULL_CNT && wr_ptr == '0) rewind_cnt = FULL_CNT;
    else                                   rewind_cnt = {1'b0, wr_ptr};
  end

  always_comb begin
    if (rt_take)               next_count = rewind_cnt;
    else if (wr_acc && !rd_acc) next_count = count + 1'b1;
    else if (rd_acc && !wr_acc) next_count = count - 1'b1;
    else                        next_count = count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
      if (rt_take)     rd_ptr <= '0;
      else if (rd_acc) rd_ptr <= rd_ptr + 1'b1;
      count <= next_count;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_both_keep_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc) |=> $stable(count));
  p_rewind_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rt_take |=> (rd_ptr == '0) && $stable(wr_ptr));
endmodule

// File: rtl/retx_fifo_flags.sv
module retx_fifo_flags
  import retx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] next_count,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          rt_take,
  output fifo_flags_t   flags
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= FLAGS_AT_RESET;
    end else begin
      flags.empty <= (next_count == '0);
      flags.full  <= (next_count == FULL_CNT);
      flags.half  <= (next_count > HALF_CNT);
    end
  end

  p_half_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.half) |-> ($past(wr_acc) || $past(rt_take)));
  p_half_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags.half) |-> ($past(rd_acc) || $past(rt_take)));
  p_empty_full_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags.empty && flags.full));
endmodule

// File: rtl/retx_fifo_mem.sv
module retx_fifo_mem #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_word <= store[rd_addr];
    end
  end

  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  p_no_collision_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wr_addr != rd_addr));
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             out_req,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             rt_n,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  fifo_flags_t   flags;
  logic          wr_acc, rd_acc, rt_take;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, next_count;

  assign wr_acc  = in_valid && !flags.full;
  assign rd_acc  = out_req && !flags.empty;
  assign rt_take = !rt_n && !in_valid && !out_req;

  retx_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .rt_take(rt_take), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .next_count(next_count)
  );

  retx_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .next_count(next_count), .wr_acc(wr_acc),
    .rd_acc(rd_acc), .rt_take(rt_take), .flags(flags)
  );

  retx_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .wr_addr(wr_ptr),
    .wr_word(in_data), .rd_en(rd_acc), .rd_addr(rd_ptr),
    .rd_valid(out_valid), .rd_word(out_data)
  );

  assign in_ready = !flags.full;
  assign empty_n  = !flags.empty;
  assign full_n   = !flags.full;
  assign half_n   = !flags.half;

  p_full_holds_wptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && in_valid && !out_req) |=> !full_n);
  p_empty_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && out_req) |=> !out_valid);
  p_rewind_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n && out_req && empty_n) |=> out_valid);
endmodule

// File: tb/test_retx_fifo.sv
module test_retx_fifo;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_req = 1'b0, rt_n = 1'b1;
  logic [8:0] in_data = '0;
  logic in_ready, out_valid, empty_n, full_n, half_n;
  logic [8:0] out_data;

  int checks = 0, fails = 0;
  int mcnt = 0, mwp = 0, mrp = 0;
  logic [8:0] mmem [D];

  always #2 clk = ~clk;

  retx_fifo #(.WIDTH(9), .DEPTH(D)) i_retx_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_req(out_req), .out_valid(out_valid),
    .out_data(out_data), .rt_n(rt_n), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_flags(string tag);
    check(tag, "empty_n", 32'(empty_n), 32'(mcnt != 0));
    check(tag, "full_n", 32'(full_n), 32'(mcnt != D));
    check(tag, "half_n", 32'(half_n), 32'(!(mcnt > D / 2)));
    check(tag, "in_ready", 32'(in_ready), 32'(mcnt != D));
  endtask

  // one cycle of stimulus, model update, and output check
  task automatic op(bit w, logic [8:0] d, bit r, bit rt, string tag);
    bit wa, ra, ta;
    logic [8:0] ed;
    wa = w && (mcnt < D);
    ra = r && (mcnt > 0);
    ta = rt && !w && !r;
    ed = mmem[mrp];
    in_valid = w; in_data = d; out_req = r; rt_n = !rt;
    @(posedge clk); #1;
    in_valid = 1'b0; out_req = 1'b0; rt_n = 1'b1;
    if (ra) mrp = (mrp + 1) % D;
    if (wa) begin mmem[mwp] = d; mwp = (mwp + 1) % D; end
    mcnt = mcnt + int'(wa) - int'(ra);
    if (ta) begin
      mrp = 0;
      mcnt = (mcnt == D && mwp == 0) ? D : mwp;
    end
    check(tag, "out_valid", 32'(out_valid), 32'(ra));
    if (ra) check(tag, "out_data", 32'(out_data), 32'(ed));
    check_flags(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R2", "empty_n in reset", 32'(empty_n), 0);
    check("R2", "out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    mcnt = 0; mwp = 0; mrp = 0;
    @(posedge clk); #1;
    check("R2", "empty_n", 32'(empty_n), 0);
    check("R2", "full_n", 32'(full_n), 1);
    check("R2", "half_n", 32'(half_n), 1);
    check("R2", "in_ready", 32'(in_ready), 1);
    check("R2", "out_valid", 32'(out_valid), 0);
  endtask

  task automatic t_order();
    op(1, 9'h1A5, 0, 0, "R1");
    op(1, 9'h05A, 0, 0, "R1");
    op(1, 9'h100, 0, 0, "R1");
    repeat (3) op(0, '0, 1, 0, "R1");
  endtask

  task automatic t_empty_read();
    op(0, '0, 1, 0, "R4");
    op(0, '0, 1, 0, "R4");
    op(1, 9'h0C3, 0, 0, "R8");
    op(0, '0, 1, 0, "R8");
    op(0, '0, 1, 0, "R4");
  endtask

  task automatic t_fill();
    for (int i = 0; i < D; i++) begin
      op(1, 9'(9'h180 + i), 0, 0, "R5");
      if (i == D - 2) check("R5", "not full one early", 32'(full_n), 1);
    end
    check("R5", "full after DEPTH", 32'(full_n), 0);
    op(1, 9'h0FF, 0, 0, "R3");
    op(1, 9'h0EE, 0, 0, "R3");
    for (int i = 0; i < D; i++) op(0, '0, 1, 0, "R3");
    check("R3", "drained empty", 32'(empty_n), 0);
  endtask

  task automatic t_half();
    for (int i = 0; i < D / 2; i++) op(1, 9'(i), 0, 0, "R6");
    check("R6", "at half not set", 32'(half_n), 1);
    op(1, 9'h111, 0, 0, "R6");
    check("R6", "set past half", 32'(half_n), 0);
    op(0, '0, 1, 0, "R6");
    check("R6", "clear at half", 32'(half_n), 1);
    while (mcnt > 0) op(0, '0, 1, 0, "R6");
  endtask

  task automatic t_both();
    op(1, 9'h010, 0, 0, "R7");
    op(1, 9'h020, 0, 0, "R7");
    for (int i = 0; i < 6; i++) op(1, 9'(9'h140 + i), 1, 0, "R7");
    op(1, 9'h077, 1, 0, "R7");
    while (mcnt > 0) op(0, '0, 1, 0, "R7");
    op(1, 9'h033, 1, 0, "R7");
    op(0, '0, 1, 0, "R7");
  endtask

  task automatic t_rewind();
    do_reset();
    for (int i = 0; i < 5; i++) op(1, 9'(9'h1F0 + i), 0, 0, "R9");
    for (int i = 0; i < 3; i++) op(0, '0, 1, 0, "R9");
    op(0, '0, 0, 1, "R9");
    check("R9", "occupancy after rewind", 32'(empty_n), 1);
    for (int i = 0; i < 5; i++) op(0, '0, 1, 0, "R9");
    op(0, '0, 0, 1, "R9");
    op(0, '0, 1, 1, "R10");
    op(1, 9'h0AA, 0, 1, "R10");
    while (mcnt > 0) op(0, '0, 1, 0, "R10");
    do_reset();
    for (int i = 0; i < D / 2 + 2; i++) op(1, 9'(9'h120 + i), 0, 0, "R9");
    while (mcnt > 0) op(0, '0, 1, 0, "R9");
    op(0, '0, 0, 1, "R9");
    check("R9", "half after rewind", 32'(half_n), 0);
    while (mcnt > 0) op(0, '0, 1, 0, "R9");
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_order();
    t_empty_read();
    t_fill();
    t_half();
    t_both();
    t_rewind();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule